// File: doc/BRIEF.md
# Stack Pointer and Push/Pop Sequencer

This block owns a stack that grows toward lower addresses inside a byte-wide data SRAM. It holds the stack pointer and turns four commands from an instruction pipeline into SRAM accesses and pointer updates. The four commands are a one-byte data push, a one-byte data pop, a two-byte return-address push and a two-byte return-address pop. Software sees the pointer as two byte-wide registers, one for the low half and one for the upper bits. It can read and load either half independently.

Stores use post-decrement: the byte is written at the pointer and the pointer then steps down. Loads use pre-increment: the pointer steps up and the byte is read at the new value. A return address therefore occupies two adjacent bytes. The low byte sits at the higher address and the high byte directly below it. A single-port synchronous SRAM is modelled inside the block, so two-byte operations need a second cycle. During that cycle the block raises `busy`.

Addresses at or below a reserved floor hold registers and I/O. Any push that would bring the pointer down to the floor or lower is refused and sets a sticky error flag.

Top module: `stkptr_unit`

## Requirements
- R1: After reset the pointer is 0x25F and the error flag is low. `io_sel`=0 selects the low byte and `io_sel`=1 selects the upper bits, zero-extended. Both halves read back on `io_rdata` combinationally. A write with `io_we` loads the selected half on the next edge; on a high write, bits above the pointer width are dropped.
- R2: `cmd_op`=0 is a byte push. It writes `cmd_wdata[7:0]` at the pointer and the pointer drops by 1 on the same edge.
- R3: `cmd_op`=1 is a byte pop. The pointer rises by 1, and the byte at the new pointer appears on `rd_data[7:0]` with `rd_data[15:8]`=0. `rd_valid` is high for exactly the cycle after acceptance. Byte pops return bytes in reverse push order.
- R4: `cmd_op`=2 is an address push. Its first cycle writes `cmd_wdata[7:0]` at the pointer. Its second cycle has `busy` high, writes `cmd_wdata[15:8]` at pointer-1, and lowers the pointer by 2 at the end of that cycle.
- R5: `cmd_op`=3 is an address pop. Its second cycle has `busy` high and the pointer rises by 2 at the end of it. In the following cycle `rd_valid` is high with the byte from the old pointer+1 on `rd_data[15:8]` and the byte from the old pointer+2 on `rd_data[7:0]`. `busy` never lasts more than one cycle.
- R6: A byte push with pointer ≤ FLOOR+1, or an address push with pointer ≤ FLOOR+2 (FLOOR = 0x60), writes nothing and leaves the pointer unchanged. It sets `stk_err`, which stays high until reset.
- R7: A command presented while `busy` is high is ignored. When `io_we` and `cmd_valid` are both high in a cycle without `busy`, the I/O write takes effect and the command is ignored.
- R8: An address push followed by two byte pops returns the high byte first, then the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_we | input | 1 | Pointer register write strobe |
| io_sel | input | 1 | 0 selects the low byte, 1 selects the upper bits |
| io_wdata | input | 8 | Pointer register write data |
| io_rdata | output | 8 | Selected pointer half, combinational |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 byte push, 1 byte pop, 2 address push, 3 address pop |
| cmd_wdata | input | 16 | Push data (byte pushes use bits 7:0) |
| busy | output | 1 | Second cycle of an address push or pop |
| rd_valid | output | 1 | Pop data valid |
| rd_data | output | 16 | Pop result |
| sp_out | output | SP_AW | Current stack pointer |
| stk_err | output | 1 | Sticky floor violation flag |

## Verification
The bench builds the block with a 10-bit pointer, a reset value of 0x25F and a floor of 0x60. Loading the pointer through the register port brings it next to the floor in a few cycles. The floor checks then run at both step sizes, just above and at the limit, without pushing hundreds of bytes. The full 1 KiB address range keeps the empty reserved bytes observable. A refused push must leave those bytes unwritten, so a pop from them has to come back with anything other than the refused value.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH_B = 2'd0,
    OP_POP_B  = 2'd1,
    OP_PUSH_W = 2'd2,
    OP_POP_W  = 2'd3
  } stk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PUSH_HI = 2'd1,
    ST_POP_LO  = 2'd2
  } stk_st_e;
endpackage

// File: rtl/stk_sram.sv
module stk_sram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wd,
  output logic [7:0]    rq
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) rq <= mem[addr];
  end
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int AW      = 10,
  parameter int SP_INIT = 'h25F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [7:0]    ld_data,
  input  logic          adj_en,
  input  logic          adj_up,
  input  logic          adj_two,
  output logic [AW-1:0] sp
);
  localparam int HW = AW - 8;
  localparam logic [AW-1:0] RST_VAL = SP_INIT[AW-1:0];

  logic [AW-1:0] sp_q, sp_nxt, step;
  logic          sp_en;

  always_comb begin
    step   = adj_two ? AW'(2) : AW'(1);
    sp_nxt = sp_q;
    if (ld_lo)       sp_nxt[7:0]    = ld_data;
    else if (ld_hi)  sp_nxt[AW-1:8] = ld_data[HW-1:0];
    else if (adj_en) sp_nxt = adj_up ? sp_q + step : sp_q - step;
  end

  assign sp_en = ld_lo | ld_hi | adj_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= RST_VAL;
    else if (sp_en) sp_q <= sp_nxt;
  end

  assign sp = sp_q;
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int AW    = 10,
  parameter int FLOOR = 'h60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  stk_op_e       op,
  input  logic [15:0]   wdata,
  input  logic [AW-1:0] sp,
  input  logic [7:0]    ram_q,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wd,
  output logic          adj_en,
  output logic          adj_up,
  output logic          adj_two,
  output logic          busy,
  output logic          rd_valid,
  output logic [15:0]   rd_data,
  output logic          err
);
  localparam logic [AW:0]   LIM_B = (AW+1)'(FLOOR + 1);
  localparam logic [AW:0]   LIM_W = (AW+1)'(FLOOR + 2);
  localparam logic [AW-1:0] ONE   = AW'(1);
  localparam logic [AW-1:0] TWO   = AW'(2);

  stk_st_e    st_q, st_nxt;
  logic       rdv_nxt, rdv_q;
  logic       kind_nxt, kind_q;
  logic       wrhi_en, rdhi_en, err_set, err_q;
  logic [7:0] wr_hi_q, rd_hi_q;
  logic       low_b, low_w;

  assign low_b = {1'b0, sp} <= LIM_B;
  assign low_w = {1'b0, sp} <= LIM_W;

  always_comb begin
    st_nxt   = st_q;
    mem_we   = 1'b0;
    mem_re   = 1'b0;
    mem_addr = sp;
    mem_wd   = wdata[7:0];
    adj_en   = 1'b0;
    adj_up   = 1'b0;
    adj_two  = 1'b0;
    rdv_nxt  = 1'b0;
    kind_nxt = 1'b0;
    wrhi_en  = 1'b0;
    rdhi_en  = 1'b0;
    err_set  = 1'b0;
    unique case (st_q)
      ST_PUSH_HI: begin
        mem_we   = 1'b1;
        mem_addr = sp - ONE;
        mem_wd   = wr_hi_q;
        adj_en   = 1'b1;
        adj_two  = 1'b1;
        st_nxt   = ST_IDLE;
      end
      ST_POP_LO: begin
        mem_re   = 1'b1;
        mem_addr = sp + TWO;
        rdhi_en  = 1'b1;
        adj_en   = 1'b1;
        adj_up   = 1'b1;
        adj_two  = 1'b1;
        rdv_nxt  = 1'b1;
        kind_nxt = 1'b1;
        st_nxt   = ST_IDLE;
      end
      default: begin
        if (go) begin
          unique case (op)
            OP_PUSH_B: begin
              if (low_b) err_set = 1'b1;
              else begin
                mem_we = 1'b1;
                adj_en = 1'b1;
              end
            end
            OP_POP_B: begin
              mem_re   = 1'b1;
              mem_addr = sp + ONE;
              adj_en   = 1'b1;
              adj_up   = 1'b1;
              rdv_nxt  = 1'b1;
            end
            OP_PUSH_W: begin
              if (low_w) err_set = 1'b1;
              else begin
                mem_we  = 1'b1;
                wrhi_en = 1'b1;
                st_nxt  = ST_PUSH_HI;
              end
            end
            default: begin
              mem_re   = 1'b1;
              mem_addr = sp + ONE;
              st_nxt   = ST_POP_LO;
            end
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rdv_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_nxt;
      rdv_q <= rdv_nxt;
      if (err_set) err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rdv_nxt) kind_q  <= kind_nxt;
    if (wrhi_en) wr_hi_q <= wdata[15:8];
    if (rdhi_en) rd_hi_q <= ram_q;
  end

  assign busy     = st_q != ST_IDLE;
  assign rd_valid = rdv_q;
  assign rd_data  = kind_q ? {rd_hi_q, ram_q} : {8'h00, ram_q};
  assign err      = err_q;
endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit
  import stk_pkg::*;
#(
  parameter int SP_AW   = 10,
  parameter int SP_INIT = 'h25F,
  parameter int FLOOR   = 'h60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_we,
  input  logic             io_sel,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [15:0]      cmd_wdata,
  output logic             busy,
  output logic             rd_valid,
  output logic [15:0]      rd_data,
  output logic [SP_AW-1:0] sp_out,
  output logic             stk_err
);
  logic [SP_AW-1:0] sp, mem_addr;
  logic [15:0]      sp16;
  logic [7:0]       mem_wd, ram_q;
  logic             mem_we, mem_re, adj_en, adj_up, adj_two;
  logic             io_go, go, ld_lo, ld_hi;

  assign io_go = io_we & ~busy;
  assign ld_lo = io_go & ~io_sel;
  assign ld_hi = io_go & io_sel;
  assign go    = cmd_valid & ~busy & ~io_we;

  stk_ptr #(.AW(SP_AW), .SP_INIT(SP_INIT)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_data(io_wdata),
    .adj_en(adj_en), .adj_up(adj_up), .adj_two(adj_two), .sp(sp)
  );

  stk_seq #(.AW(SP_AW), .FLOOR(FLOOR)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .op(stk_op_e'(cmd_op)), .wdata(cmd_wdata),
    .sp(sp), .ram_q(ram_q), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wd(mem_wd), .adj_en(adj_en), .adj_up(adj_up), .adj_two(adj_two),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .err(stk_err)
  );

  stk_sram #(.AW(SP_AW)) u_ram (
    .clk(clk), .we(mem_we), .re(mem_re), .addr(mem_addr), .wd(mem_wd), .rq(ram_q)
  );

  assign sp16     = 16'(sp);
  assign io_rdata = io_sel ? sp16[15:8] : sp16[7:0];
  assign sp_out   = sp;
endmodule

// File: rtl/stkptr_unit_chk.sv
module stkptr_unit_chk #(
  parameter int SP_AW = 10,
  parameter int FLOOR = 'h60
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_we,
  input logic             io_sel,
  input logic [7:0]       io_wdata,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic             busy,
  input logic             rd_valid,
  input logic [SP_AW-1:0] sp_out,
  input logic             stk_err
);
  logic acc;
  assign acc = cmd_valid & ~busy & ~io_we;

  AST_IO_LOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && !busy && !io_sel) |=> sp_out[7:0] == $past(io_wdata)); // R1

  AST_BYTE_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd0 && sp_out > FLOOR + 1) |=> sp_out == $past(sp_out) - SP_AW'(1)); // R2

  AST_BYTE_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd1) |=> rd_valid && sp_out == $past(sp_out) + SP_AW'(1)); // R3

  AST_WORD_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd2 && sp_out > FLOOR + 2) |=> busy && $stable(sp_out)); // R4

  AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy); // R5

  AST_FLOOR_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd0 && sp_out <= FLOOR + 1) |=> stk_err && $stable(sp_out)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |=> stk_err); // R6

  AST_IO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && !busy && io_sel) |=> !busy && !rd_valid && sp_out[7:0] == $past(sp_out[7:0])); // R7
endmodule

bind stkptr_unit stkptr_unit_chk #(.SP_AW(SP_AW), .FLOOR(FLOOR)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_we(io_we), .io_sel(io_sel), .io_wdata(io_wdata),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .busy(busy), .rd_valid(rd_valid),
  .sp_out(sp_out), .stk_err(stk_err)
);

// File: tb/stkptr_unit_test.sv
`timescale 1ns/1ps
module stkptr_unit_test;
  localparam int AW = 10;
  localparam int INIT = 'h25F;
  localparam int FLR = 'h60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_we = 1'b0, io_sel = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [15:0] cmd_wdata = 16'h0;
  logic        busy, rd_valid, stk_err;
  logic [15:0] rd_data;
  logic [AW-1:0] sp_out;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stkptr_unit #(.SP_AW(AW), .SP_INIT(INIT), .FLOOR(FLR)) uut (
    .clk(clk), .rst_n(rst_n), .io_we(io_we), .io_sel(io_sel), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .sp_out(sp_out), .stk_err(stk_err)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0]    m_mem [0:1023];
  logic [AW-1:0] m_sp;
  logic          m_err, m_rdv;
  logic [15:0]   m_rdat;
  logic [7:0]    m_hold;
  int            m_st;
  string         m_req = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sp = AW'(INIT); m_err = 1'b0; m_st = 0; m_rdv = 1'b0;
    end else begin
      m_rdv = 1'b0;
      if (m_st == 1) begin
        m_mem[m_sp - 1'b1] = m_hold; m_sp = m_sp - 2'd2; m_st = 0; m_req = "R4";
      end else if (m_st == 2) begin
        m_rdv = 1'b1; m_rdat = {m_mem[m_sp + 1'b1], m_mem[m_sp + 2'd2]};
        m_sp = m_sp + 2'd2; m_st = 0; m_req = "R5";
      end else if (io_we) begin
        if (io_sel) m_sp[AW-1:8] = io_wdata[AW-9:0]; else m_sp[7:0] = io_wdata;
        m_req = "R7";
      end else if (cmd_valid) begin
        case (cmd_op)
          2'd0: begin
            m_req = "R2";
            if (int'(m_sp) <= FLR + 1) m_err = 1'b1;
            else begin m_mem[m_sp] = cmd_wdata[7:0]; m_sp = m_sp - 1'b1; end
          end
          2'd1: begin
            m_req = "R3"; m_sp = m_sp + 1'b1; m_rdv = 1'b1; m_rdat = {8'h00, m_mem[m_sp]};
          end
          2'd2: begin
            m_req = "R4";
            if (int'(m_sp) <= FLR + 2) m_err = 1'b1;
            else begin m_mem[m_sp] = cmd_wdata[7:0]; m_hold = cmd_wdata[15:8]; m_st = 1; end
          end
          default: begin m_req = "R5"; m_st = 2; end
        endcase
      end
    end
  end

  // clock-by-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(sp_out === m_sp, {m_req, " trace sp"}, 16'(sp_out), 16'(m_sp));
      chk(stk_err === m_err, "R6 trace err", 16'(stk_err), 16'(m_err));
      chk(busy === (m_st != 0), "R7 trace busy", 16'(busy), 16'(m_st != 0));
      chk(rd_valid === m_rdv, {m_req, " trace rd_valid"}, 16'(rd_valid), 16'(m_rdv));
      if (m_rdv) chk(rd_data === m_rdat, {m_req, " trace rd_data"}, rd_data, m_rdat);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // tasks start at a falling edge and return at the next one
  task automatic drive(input bit we, input bit sel, input logic [7:0] iod,
                       input bit cv, input logic [1:0] op, input logic [15:0] d);
    #1;
    io_we = we; io_sel = sel; io_wdata = iod;
    cmd_valid = cv; cmd_op = op; cmd_wdata = d;
    @(negedge clk);
  endtask
  task automatic nop(); drive(0, io_sel, 8'h00, 0, 2'd0, 16'h0); endtask
  task automatic cmd(input logic [1:0] op, input logic [15:0] d); drive(0, io_sel, 8'h00, 1, op, d); endtask
  task automatic iow(input bit sel, input logic [7:0] v); drive(1, sel, v, 0, 2'd0, 16'h0); endtask
  task automatic look(input bit sel, input logic [7:0] exp, input string req);
    #1; io_we = 1'b0; cmd_valid = 1'b0; io_sel = sel;
    #1; chk(io_rdata === exp, req, 16'(io_rdata), 16'(exp));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sp_out === 10'h25F, "R1 reset sp", 16'(sp_out), 16'h25F);
    chk(stk_err === 1'b0, "R1 reset err", 16'(stk_err), 16'h0);
    look(0, 8'h5F, "R1 low read");
    look(1, 8'h02, "R1 high read");

    cmd(0, 16'h0012); chk(sp_out === 10'h25E, "R2 push1 sp", 16'(sp_out), 16'h25E);
    cmd(0, 16'h0034); chk(sp_out === 10'h25D, "R2 push2 sp", 16'(sp_out), 16'h25D);
    cmd(0, 16'h0056); chk(sp_out === 10'h25C, "R2 push3 sp", 16'(sp_out), 16'h25C);
    cmd(1, 16'h0); chk(rd_valid && rd_data === 16'h0056, "R3 pop 56", rd_data, 16'h0056);
    cmd(1, 16'h0); chk(rd_data === 16'h0034, "R3 pop 34", rd_data, 16'h0034);
    cmd(1, 16'h0); chk(rd_data === 16'h0012, "R3 pop 12", rd_data, 16'h0012);
    chk(sp_out === 10'h25F, "R3 sp back", 16'(sp_out), 16'h25F);

    cmd(2, 16'hABCD);
    chk(busy === 1'b1, "R4 busy second cycle", 16'(busy), 16'h1);
    chk(sp_out === 10'h25F, "R4 sp held", 16'(sp_out), 16'h25F);
    cmd(0, 16'h00EE);   // presented while busy: ignored
    chk(sp_out === 10'h25D, "R7 busy command ignored", 16'(sp_out), 16'h25D);
    nop();
    cmd(1, 16'h0); chk(rd_data === 16'h00AB, "R8 high byte first", rd_data, 16'h00AB);
    cmd(1, 16'h0); chk(rd_data === 16'h00CD, "R8 low byte second", rd_data, 16'h00CD);

    cmd(2, 16'h1357); nop();
    cmd(3, 16'h0); chk(busy === 1'b1, "R5 busy", 16'(busy), 16'h1);
    nop(); chk(rd_valid && rd_data === 16'h1357, "R5 address pop", rd_data, 16'h1357);
    chk(sp_out === 10'h25F, "R5 sp", 16'(sp_out), 16'h25F);

    cmd(2, 16'h1111); nop(); cmd(2, 16'h2222); nop();
    cmd(3, 16'h0); nop(); chk(rd_data === 16'h2222, "R5 nested inner", rd_data, 16'h2222);
    cmd(3, 16'h0); nop(); chk(rd_data === 16'h1111, "R5 nested outer", rd_data, 16'h1111);

    drive(1, 0, 8'h40, 1, 2'd0, 16'h00AA);
    chk(sp_out === 10'h240, "R7 io write wins", 16'(sp_out), 16'h240);
    iow(1, 8'hFD);
    chk(sp_out === 10'h140, "R1 high write truncated", 16'(sp_out), 16'h140);
    look(1, 8'h01, "R1 high readback");

    iow(1, 8'h00); iow(0, 8'h63);
    cmd(0, 16'h0077); cmd(0, 16'h0088);
    chk(sp_out === 10'h061 && !stk_err, "R6 push above floor", 16'(sp_out), 16'h061);
    cmd(0, 16'h0099);
    chk(stk_err === 1'b1, "R6 byte refused err", 16'(stk_err), 16'h1);
    chk(sp_out === 10'h061, "R6 byte refused sp", 16'(sp_out), 16'h061);
    iow(0, 8'h62);
    cmd(2, 16'h5566);
    chk(busy === 1'b0 && sp_out === 10'h062, "R6 address refused", 16'(sp_out), 16'h062);
    iow(0, 8'h60);
    cmd(1, 16'h0);
    chk(rd_data[7:0] !== 8'h99, "R6 refused byte not written", rd_data, 16'h0000);
    cmd(1, 16'h0); chk(rd_data === 16'h0088, "R6 pop 88", rd_data, 16'h0088);
    cmd(1, 16'h0); chk(rd_data === 16'h0077, "R6 pop 77", rd_data, 16'h0077);
    nop(); nop();
    chk(stk_err === 1'b1, "R6 sticky", 16'(stk_err), 16'h1);

    #1 rst_n = 1'b0;
    @(negedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(stk_err === 1'b0 && sp_out === 10'h25F, "R1 reset clears", 16'(sp_out), 16'h25F);
    nop(); nop();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule